// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block keeps the per-vector interrupt state of one processor. It holds three 256-bit arrays: pending requests, vectors in service, and the trigger type last seen for each vector. Requests enter as a vector number plus a level/edge flag. From these arrays and a task-priority value, the block computes a processor priority. It raises an interrupt line when the highest pending vector belongs to a priority class above that priority.

The processor side uses two single-cycle strobes. An acknowledge answers one cycle later with one of three results: a real vector, which moves from pending to in service; a spurious vector, when the task priority blocks delivery; or nothing, when delivery is disabled or no vector is pending. An end-of-interrupt retires the highest vector in service.

The task priority can be written two ways: as a full byte, or through a 4-bit port that carries only the class. A 9-bit spurious-vector register holds the software-enable bit and the spurious code. Any 32-bit word of the three arrays can be read combinationally. A free-running counter counts requests that found their vector not already pending.

Top module: `irq_prio_ctl`

## Requirements
- R1: A request (`req_valid` high at a clock edge) sets pending bit `req_vector`. It also sets trigger bit `req_vector` to `req_level`: 1 means level, 0 means edge. Both are visible after that edge.
- R2: `deliver_cnt` resets to 0. It increments by one, wrapping, for each request whose vector was not pending before that edge. A request to a vector that is already pending leaves it unchanged.
- R3: `irq` is high only when all three hold: spurious-vector bit 8 (the enable) is 1; some vector is pending; and either `ppr_out` is 0 or bits [7:4] of the highest pending vector exceed bits [7:4] of `ppr_out`.
- R4: `ppr_out` equals the task priority when nothing is in service, or when the task priority's bits [7:4] are at least bits [7:4] of the highest in-service vector. Otherwise it equals that in-service vector with bits [3:0] cleared.
- R5: `ack_done` is high exactly in the cycle after an `ack_req`. On a granted acknowledge, `ack_kind` is 1 and `ack_vector` is the highest pending vector. In the same edge, that vector's pending bit is cleared and its in-service bit is set.
- R6: An acknowledge returns `ack_kind` 0 when the enable bit is 0 or nothing is pending. It returns `ack_kind` 2 with `ack_vector` equal to spurious-vector bits [7:0] when the task priority is nonzero and the highest pending vector is not above it. In these cases the arrays are left unchanged.
- R7: `eoi` clears the highest set in-service bit. With nothing in service it has no effect.
- R8: A nibble write stores `{nib_wdata, 4'b0}` as the task priority. `nib_rdata` returns task-priority bits [7:4]. A full write stores `tpr_wdata`, which `tpr_rdata` returns.
- R9: A spurious-vector write keeps `svr_wdata[8:0]`. Reset sets that register to 0x0FF, the task priority to 0, all three arrays to 0, and `ack_done` to 0.
- R10: `rd_data` is bits [32*`rd_word`+31 : 32*`rd_word`] of the array chosen by `rd_sel`: 0 pending, 1 in service, 2 trigger, 3 reads zero.
- R11: Events in the same cycle resolve as follows. A request sets its pending bit even if an acknowledge clears that vector in the same edge. An acknowledge's in-service set wins over an end-of-interrupt clear of the same bit. A full task-priority write wins over a nibble write. The duplicate test for R2 uses the pending state from before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Vector request strobe |
| req_vector | input | 8 | Requested vector |
| req_level | input | 1 | 1 level-triggered, 0 edge-triggered |
| ack_req | input | 1 | Acknowledge strobe |
| ack_done | output | 1 | Acknowledge result valid |
| ack_kind | output | 2 | 0 none, 1 vector, 2 spurious |
| ack_vector | output | 8 | Returned vector |
| eoi | input | 1 | End-of-interrupt strobe |
| tpr_wr | input | 1 | Full task-priority write |
| tpr_wdata | input | 8 | Task priority value |
| tpr_rdata | output | 8 | Task priority |
| nib_wr | input | 1 | Class-only task-priority write |
| nib_wdata | input | 4 | Class value |
| nib_rdata | output | 4 | Task priority class |
| svr_wr | input | 1 | Spurious-vector register write |
| svr_wdata | input | 32 | Write data, bits [8:0] kept |
| svr_rdata | output | 9 | Spurious-vector register |
| rd_sel | input | 2 | Array select for reads |
| rd_word | input | 3 | Word index for reads |
| rd_data | output | 32 | Selected array word |
| ppr_out | output | 8 | Processor priority |
| irq | output | 1 | Interrupt request to the processor |
| deliver_cnt | output | 16 | Count of newly pending requests |

## Verification
Acknowledge and end-of-interrupt can land on the same edge. The acknowledge may pick a vector that is also the one being retired. A request may also arrive for the very vector the acknowledge clears. The bench provokes these collisions with directed cycles and with a long stretch of random strobes over a small set of vectors. It judges them against a behavioural model that applies the R11 ordering to the pre-edge state. Outputs, priority and a rotating array-word read are compared on every clock.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    typedef enum logic [1:0] {
        ACK_NONE     = 2'd0,
        ACK_VECTOR   = 2'd1,
        ACK_SPURIOUS = 2'd2
    } ack_kind_e;

    typedef enum logic [1:0] {
        RD_PEND  = 2'd0,
        RD_INSVC = 2'd1,
        RD_TRIG  = 2'd2,
        RD_ZERO  = 2'd3
    } rd_sel_e;

    localparam int CLASS_W = 4;
    localparam int WORD_W  = 32;
endpackage

// File: rtl/prio_find.sv
module prio_find #(
    parameter int N = 256,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  bits_in,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |bits_in;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (bits_in[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/prio_gate.sv
module prio_gate
    import irq_prio_pkg::*;
#(
    parameter int VW = 8
) (
    input  logic [VW-1:0] tpr,
    input  logic          sw_en,
    input  logic          pend_any,
    input  logic [VW-1:0] pend_hp,
    input  logic          isr_any,
    input  logic [VW-1:0] isr_hp,
    output logic [VW-1:0] ppr,
    output logic          irq,
    output ack_kind_e     ack_now
);
    localparam int CH = VW - 1;
    localparam int CL = VW - CLASS_W;

    always_comb begin
        if (!isr_any || tpr[CH:CL] >= isr_hp[CH:CL])
            ppr = tpr;
        else
            ppr = {isr_hp[CH:CL], {CL{1'b0}}};
    end

    assign irq = sw_en && pend_any &&
                 ((ppr == '0) || (pend_hp[CH:CL] > ppr[CH:CL]));

    always_comb begin
        if (!sw_en || !pend_any)
            ack_now = ACK_NONE;
        else if ((tpr != '0) && (pend_hp <= tpr))
            ack_now = ACK_SPURIOUS;
        else
            ack_now = ACK_VECTOR;
    end
endmodule

// File: rtl/irq_prio_ctl.sv
module irq_prio_ctl
    import irq_prio_pkg::*;
#(
    parameter int VEC_N = 256,
    parameter int CNT_W = 16,
    localparam int VW   = $clog2(VEC_N),
    localparam int NW   = VEC_N / WORD_W,
    localparam int WSEL = $clog2(NW),
    localparam int SW   = VW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VW-1:0]    req_vector,
    input  logic             req_level,
    input  logic             ack_req,
    output logic             ack_done,
    output logic [1:0]       ack_kind,
    output logic [VW-1:0]    ack_vector,
    input  logic             eoi,
    input  logic             tpr_wr,
    input  logic [VW-1:0]    tpr_wdata,
    output logic [VW-1:0]    tpr_rdata,
    input  logic             nib_wr,
    input  logic [3:0]       nib_wdata,
    output logic [3:0]       nib_rdata,
    input  logic             svr_wr,
    input  logic [31:0]      svr_wdata,
    output logic [SW-1:0]    svr_rdata,
    input  logic [1:0]       rd_sel,
    input  logic [WSEL-1:0]  rd_word,
    output logic [31:0]      rd_data,
    output logic [VW-1:0]    ppr_out,
    output logic             irq,
    output logic [CNT_W-1:0] deliver_cnt
);
    logic [VEC_N-1:0] pend_q, isr_q, tmr_q;
    logic [VW-1:0]    tpr_q;
    logic [SW-1:0]    svr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ack_done_q;
    ack_kind_e        ack_kind_q;
    logic [VW-1:0]    ack_vec_q;

    logic          pend_any, isr_any;
    logic [VW-1:0] pend_hp, isr_hp;
    ack_kind_e     ack_now;
    logic          ack_go;

    logic [VEC_N-1:0] pend_clr, isr_clr, req_set;

    prio_find #(.N(VEC_N)) u_pend_find (
        .bits_in(pend_q), .any(pend_any), .idx(pend_hp)
    );
    prio_find #(.N(VEC_N)) u_isr_find (
        .bits_in(isr_q), .any(isr_any), .idx(isr_hp)
    );

    prio_gate #(.VW(VW)) u_gate (
        .tpr(tpr_q), .sw_en(svr_q[SW-1]),
        .pend_any(pend_any), .pend_hp(pend_hp),
        .isr_any(isr_any), .isr_hp(isr_hp),
        .ppr(ppr_out), .irq(irq), .ack_now(ack_now)
    );

    assign ack_go   = ack_req && (ack_now == ACK_VECTOR);
    assign pend_clr = ack_go ? (VEC_N'(1) << pend_hp) : '0;
    assign isr_clr  = (eoi && isr_any) ? (VEC_N'(1) << isr_hp) : '0;
    assign req_set  = req_valid ? (VEC_N'(1) << req_vector) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            isr_q  <= '0;
            tmr_q  <= '0;
            cnt_q  <= '0;
        end else begin
            // request set after acknowledge clear; acknowledge set after eoi clear
            pend_q <= (pend_q & ~pend_clr) | req_set;
            isr_q  <= (isr_q & ~isr_clr) | pend_clr;
            if (req_valid) begin
                tmr_q[req_vector] <= req_level;
                if (!pend_q[req_vector]) cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tpr_q <= '0;
            svr_q <= SW'(9'h0FF);
        end else begin
            if (tpr_wr)
                tpr_q <= tpr_wdata;
            else if (nib_wr)
                tpr_q <= {nib_wdata, {(VW-CLASS_W){1'b0}}};
            if (svr_wr) svr_q <= svr_wdata[SW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_done_q <= 1'b0;
            ack_kind_q <= ACK_NONE;
            ack_vec_q  <= '0;
        end else begin
            ack_done_q <= ack_req;
            ack_kind_q <= ack_req ? ack_now : ACK_NONE;
            ack_vec_q  <= (ack_now == ACK_SPURIOUS) ? svr_q[VW-1:0] : pend_hp;
        end
    end

    assign ack_done    = ack_done_q;
    assign ack_kind    = ack_kind_q;
    assign ack_vector  = ack_vec_q;
    assign tpr_rdata   = tpr_q;
    assign nib_rdata   = tpr_q[VW-1:VW-CLASS_W];
    assign svr_rdata   = svr_q;
    assign deliver_cnt = cnt_q;

    logic [31:0] pend_w [NW];
    logic [31:0] isr_w  [NW];
    logic [31:0] tmr_w  [NW];
    for (genvar g = 0; g < NW; g++) begin : g_word
        assign pend_w[g] = pend_q[g*WORD_W +: WORD_W];
        assign isr_w[g]  = isr_q[g*WORD_W +: WORD_W];
        assign tmr_w[g]  = tmr_q[g*WORD_W +: WORD_W];
    end

    always_comb begin
        unique case (rd_sel_e'(rd_sel))
            RD_PEND:  rd_data = pend_w[rd_word];
            RD_INSVC: rd_data = isr_w[rd_word];
            RD_TRIG:  rd_data = tmr_w[rd_word];
            default:  rd_data = '0;
        endcase
    end

    AST_REQ_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> pend_q[$past(req_vector)]); // R1
    AST_TRIG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> tmr_q[$past(req_vector)] == $past(req_level)); // R1
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(cnt_q)); // R2
    AST_NO_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !svr_q[SW-1] |-> !irq); // R3
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> ack_done); // R5
    AST_ACK_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        ack_go |=> isr_q[$past(pend_hp)]); // R5
    AST_BLOCKED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !ack_go && !req_valid && !eoi) |=> ($stable(pend_q) && $stable(isr_q))); // R6
    AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && isr_any && !ack_go) |=> !isr_q[$past(isr_hp)]); // R7
endmodule

// File: tb/irq_prio_ctl_bench.sv
module irq_prio_ctl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_level = 0, ack_req = 0, eoi = 0;
    logic [7:0] req_vector = 0, tpr_wdata = 0;
    logic tpr_wr = 0, nib_wr = 0, svr_wr = 0;
    logic [3:0] nib_wdata = 0;
    logic [31:0] svr_wdata = 0;
    logic [1:0] rd_sel = 0;
    logic [2:0] rd_word = 0;
    logic ack_done, irq;
    logic [1:0] ack_kind;
    logic [7:0] ack_vector, tpr_rdata, ppr_out;
    logic [3:0] nib_rdata;
    logic [8:0] svr_rdata;
    logic [31:0] rd_data;
    logic [15:0] deliver_cnt;

    always #4 clk = ~clk;

    irq_prio_ctl u_irq_prio_ctl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vector(req_vector), .req_level(req_level),
        .ack_req(ack_req), .ack_done(ack_done), .ack_kind(ack_kind), .ack_vector(ack_vector),
        .eoi(eoi),
        .tpr_wr(tpr_wr), .tpr_wdata(tpr_wdata), .tpr_rdata(tpr_rdata),
        .nib_wr(nib_wr), .nib_wdata(nib_wdata), .nib_rdata(nib_rdata),
        .svr_wr(svr_wr), .svr_wdata(svr_wdata), .svr_rdata(svr_rdata),
        .rd_sel(rd_sel), .rd_word(rd_word), .rd_data(rd_data),
        .ppr_out(ppr_out), .irq(irq), .deliver_cnt(deliver_cnt)
    );

    int n_checks = 0, n_fail = 0, cyc_n = 0;
    logic [255:0] mp, mi, mt;
    int mtpr, msvr, mcnt, e_done, e_kind, e_vec;

    function automatic int hi(input logic [255:0] b);
        for (int i = 255; i >= 0; i--) if (b[i]) return i;
        return -1;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_update();
        int ph, ih;
        logic [255:0] op;
        if (!rst_n) begin
            mp = '0; mi = '0; mt = '0; mtpr = 0; msvr = 'h0FF; mcnt = 0;
            e_done = 0; e_kind = 0; e_vec = 0;
            return;
        end
        ph = hi(mp); ih = hi(mi); op = mp;
        e_done = ack_req; e_kind = 0; e_vec = 0;
        if (ack_req) begin
            if (msvr[8] == 0 || ph < 0) e_kind = 0;
            else if (mtpr != 0 && ph <= mtpr) begin e_kind = 2; e_vec = msvr & 255; end
            else begin e_kind = 1; e_vec = ph; end
        end
        if (eoi && ih >= 0) mi[ih] = 1'b0;
        if (ack_req && e_kind == 1) begin mp[ph] = 1'b0; mi[ph] = 1'b1; end
        if (req_valid) begin
            if (!op[req_vector]) mcnt = (mcnt + 1) & 'hFFFF;
            mp[req_vector] = 1'b1;
            mt[req_vector] = req_level;
        end
        if (tpr_wr) mtpr = tpr_wdata;
        else if (nib_wr) mtpr = nib_wdata << 4;
        if (svr_wr) msvr = svr_wdata & 'h1FF;
    endtask

    task automatic compare();
        int ph, ih, ppr, eirq, erd;
        logic [255:0] arr;
        ph = hi(mp); ih = hi(mi);
        ppr = (ih >= 0 && (mtpr >> 4) < (ih >> 4)) ? (ih & 'hF0) : mtpr;
        eirq = (msvr[8] && ph >= 0 && (ppr == 0 || (ph >> 4) > (ppr >> 4))) ? 1 : 0;
        chk("R4 ppr_out", ppr_out, ppr);
        chk("R3 irq", irq, eirq);
        chk("R2 deliver_cnt", deliver_cnt, mcnt);
        chk("R5 ack_done", ack_done, e_done);
        if (e_done != 0) begin
            chk("R6 ack_kind", ack_kind, e_kind);
            if (e_kind != 0) chk("R5 ack_vector", ack_vector, e_vec);
        end
        chk("R8 tpr_rdata", tpr_rdata, mtpr);
        chk("R8 nib_rdata", nib_rdata, mtpr >> 4);
        chk("R9 svr_rdata", svr_rdata, msvr);
        arr = (rd_sel == 0) ? mp : (rd_sel == 1) ? mi : (rd_sel == 2) ? mt : '0;
        erd = arr[rd_word*32 +: 32];
        chk("R10 rd_data", rd_data, erd);
        // R1 R7 R11 are judged through the array words above and the priority outputs
        {rd_sel, rd_word} = {rd_sel, rd_word} + 5'd1;
    endtask

    task automatic cyc();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        req_valid = 0; ack_req = 0; eoi = 0; tpr_wr = 0; nib_wr = 0; svr_wr = 0;
    endtask

    task automatic req(input int v, input int lvl);
        req_valid = 1; req_vector = 8'(v); req_level = lvl[0]; cyc(); idle();
    endtask

    task automatic ack();
        ack_req = 1; cyc(); idle(); cyc();
    endtask

    task automatic end_int();
        eoi = 1; cyc(); idle();
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc_n++;
        if (cyc_n > 150000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        for (int i = 0; i < 3; i++) cyc();            // R9 reset values
        rst_n = 1;
        cyc();
        // R1 R2: edge then duplicate then level
        req('h31, 0); req('h31, 0); req('h45, 1);
        // R6: enable clear returns nothing
        ack();
        // R9: only 9 bits kept, enables delivery
        svr_wr = 1; svr_wdata = 32'hFFFF_F1FF; cyc(); idle();
        // R5: grant of 0x45, R4 priority now class 4
        ack();
        req('h52, 0); ack();
        // R7: retire 0x52
        end_int();
        // R8: class-only write gives 0x50; R6 spurious with 0x31 pending
        nib_wr = 1; nib_wdata = 4'h5; cyc(); idle();
        ack();
        req('h50, 0); ack();
        // R3: 0x5F not above class of priority, yet acknowledge grants it
        req('h5F, 1); cyc(); ack();
        // R11: ack, eoi and request of the acknowledged vector together
        tpr_wr = 1; tpr_wdata = 8'h00; cyc(); idle();
        req('h70, 0);
        ack_req = 1; eoi = 1; req_valid = 1; req_vector = 8'h70; req_level = 1; cyc(); idle(); cyc();
        // R11: full and nibble task-priority writes together
        tpr_wr = 1; tpr_wdata = 8'h23; nib_wr = 1; nib_wdata = 4'hA; cyc(); idle();
        // R7: drain in-service, including eoi with nothing in service
        for (int i = 0; i < 6; i++) end_int();
        // R6: nothing pending after draining
        tpr_wr = 1; tpr_wdata = 8'h00; cyc(); idle();
        for (int i = 0; i < 8; i++) ack();
        ack();
        for (int i = 0; i < 40; i++) cyc();
        // random collisions over a small vector set
        for (int i = 0; i < 3000; i++) begin
            int s;
            s = $urandom % 8;
            req_valid = ($urandom % 3) == 0;
            case (s)
                0: req_vector = 8'h21; 1: req_vector = 8'h35; 2: req_vector = 8'h3A;
                3: req_vector = 8'h47; 4: req_vector = 8'h60; 5: req_vector = 8'h8F;
                6: req_vector = 8'hF0; default: req_vector = 8'h05;
            endcase
            req_level = $urandom % 2;
            ack_req = ($urandom % 4) == 0;
            eoi = ($urandom % 5) == 0;
            tpr_wr = ($urandom % 40) == 0;
            tpr_wdata = 8'($urandom % 256);
            nib_wr = ($urandom % 40) == 0;
            nib_wdata = 4'($urandom % 16);
            svr_wr = ($urandom % 60) == 0;
            svr_wdata = (($urandom % 4) != 0) ? 32'h0000_01E7 : 32'h0000_00E7;
            cyc();
        end
        idle();
        cyc(); cyc();
        finish_run();
    end
endmodule